// File: doc/BRIEF.md
# Triangular PWM Period Dither Generator

This block sets the length of each PWM period for a downstream PWM counter. In fixed mode every period lasts a programmed base number of clock cycles. In dithered mode the period length walks upward from the base in equal increments, turns at a programmed number of levels, walks back down to the base, and repeats. Each level is held for a programmed number of whole PWM periods. The result is a triangular sweep of the switching frequency, which spreads the emission energy of the switching edges over a wider band.

The block runs its own period counter. It presents the running count, the length of the current period and a one-cycle strobe at the first cycle of every period. A new length only takes effect at a period boundary. The configuration (base, increment, dwell and number of levels) is captured only at boundaries where the sweep lands on the base level. This includes every boundary in fixed mode and the boundary at which dithering is switched off. A half-finished sweep therefore always uses one consistent set of values.

Top module: `pwm_dither_gen`

## Requirements
- R1: With a current period length P of 2 or more, `period_cnt` counts 0, 1, ..., P-1 and then returns to 0, so strobes are exactly P cycles apart. A length of 0 or 1 gives a strobe on every cycle, with the count held at 0.
- R2: `period_start` is high for exactly the first cycle of each period. In that cycle `period_cnt` is 0 and `period_len` already shows the new length.
- R3: While `dith_en` is low, every period boundary loads `base_period` as the new length.
- R4: While `dith_en` is high with a level count N of 1 or more, the level index goes 0, 1, ..., N, N-1, ..., 1, 0, 1, ... from one level change to the next. The length at level k is base + k * step.
- R5: Each level is held for `dwell_periods` + 1 consecutive PWM periods before the level changes.
- R6: With a captured level count of 0, dithering leaves every period at the base length.
- R7: `period_len` changes only in a cycle where `period_start` is high.
- R8: The base, step, dwell and level count are captured only at a boundary whose next level is 0. Changes made while the sweep is away from the base are ignored until it returns.
- R9: A boundary with `dith_en` low forces level 0, upward direction and dwell count 0. After re-enabling, the sweep starts again from the base and moves upward.
- R10: A length that exceeds the width of `period_len` saturates to all ones.
- R11: During reset, `period_cnt` and `period_len` are 0 and `period_start` is low. The first clock edge after release starts a period at the base length and raises the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released on a clock edge |
| dith_en | input | 1 | 1 = triangular dither, 0 = fixed base period |
| base_period | input | PER_W | Base period length in clock cycles |
| step_size | input | STEP_W | Length added per level |
| dwell_periods | input | DWELL_W | Extra PWM periods held at each level |
| step_count | input | NSTEP_W | Highest level of the sweep |
| period_len | output | PER_W | Length of the current PWM period |
| period_cnt | output | PER_W | Cycle position inside the current period |
| period_start | output | 1 | One-cycle strobe at the first cycle of each period |

## Verification
Directed sweeps with a nonzero dwell show the exact sequence of lengths. This separates a wrong turning point, such as repeating or skipping the top level, from a wrong hold count. A step-size change made in the middle of a sweep must not show up before the next base level, which separates boundary-gated capture from capture at any time. Disabling mid-sweep, a level count of zero, lengths of 0 and 1, and a base near full scale show the reset-to-base behaviour, the degenerate sweep, the one-cycle period and saturation. Long random runs that change the configuration and toggle the enable at arbitrary cycles are compared cycle by cycle with a bench model of the count, the strobe and the length.

// File: rtl/pwm_dither_pkg.sv
package pwm_dither_pkg;
  typedef enum logic {
    SWEEP_DOWN = 1'b0,
    SWEEP_UP   = 1'b1
  } sweep_dir_e;
endpackage

// File: rtl/pwm_period_counter.sv
module pwm_period_counter #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] len_next,
  output logic [PER_W-1:0] cnt,
  output logic [PER_W-1:0] len,
  output logic             start,
  output logic             wrap,
  output logic             first
);
  logic [PER_W-1:0] cnt_q, cnt_d, len_q, len_d;
  logic             start_q, first_q;
  logic [PER_W:0]   cnt_inc;

  // first_q forces a boundary on the first edge after reset release
  assign cnt_inc = {1'b0, cnt_q} + (PER_W+1)'(1);
  assign wrap    = first_q | (cnt_inc >= {1'b0, len_q});

  always_comb begin
    cnt_d = cnt_inc[PER_W-1:0];
    len_d = len_q;
    if (wrap) begin
      cnt_d = '0;
      len_d = len_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      len_q   <= '0;
      start_q <= 1'b0;
      first_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      start_q <= wrap;
      first_q <= 1'b0;
    end
  end

  assign cnt   = cnt_q;
  assign len   = len_q;
  assign start = start_q;
  assign first = first_q;
endmodule

// File: rtl/pwm_dither_stepper.sv
module pwm_dither_stepper
  import pwm_dither_pkg::*;
#(
  parameter int PER_W   = 16,
  parameter int STEP_W  = 8,
  parameter int DWELL_W = 4,
  parameter int NSTEP_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wrap,
  input  logic               first,
  input  logic               en,
  input  logic [PER_W-1:0]   cfg_base,
  input  logic [STEP_W-1:0]  cfg_step,
  input  logic [DWELL_W-1:0] cfg_dwell,
  input  logic [NSTEP_W-1:0] cfg_steps,
  output logic [NSTEP_W-1:0] lvl_next,
  output logic [NSTEP_W-1:0] lvl,
  output logic [PER_W-1:0]   base_snap,
  output logic [STEP_W-1:0]  step_snap,
  output logic [NSTEP_W-1:0] steps_snap
);
  logic [NSTEP_W-1:0] lvl_q, lvl_d;
  logic [DWELL_W-1:0] dw_q, dw_d;
  sweep_dir_e         dir_q, dir_d;
  logic [PER_W-1:0]   base_q;
  logic [STEP_W-1:0]  step_q;
  logic [DWELL_W-1:0] dwell_q;
  logic [NSTEP_W-1:0] steps_q;
  logic               snap;

  always_comb begin
    lvl_d = lvl_q;
    dir_d = dir_q;
    dw_d  = dw_q;
    if (first || !en) begin
      lvl_d = '0;
      dir_d = SWEEP_UP;
      dw_d  = '0;
    end else if (dw_q < dwell_q) begin
      dw_d = dw_q + DWELL_W'(1);
    end else begin
      dw_d = '0;
      if (steps_q == '0) begin
        lvl_d = '0;
        dir_d = SWEEP_UP;
      end else if (dir_q == SWEEP_UP) begin
        lvl_d = lvl_q + NSTEP_W'(1);
        if (lvl_d >= steps_q) dir_d = SWEEP_DOWN;
      end else begin
        lvl_d = lvl_q - NSTEP_W'(1);
        if (lvl_d == '0) dir_d = SWEEP_UP;
      end
    end
  end

  // configuration is captured only on boundaries that land on the base level
  assign snap = wrap && (lvl_d == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      dir_q <= SWEEP_UP;
      dw_q  <= '0;
    end else if (wrap) begin
      lvl_q <= lvl_d;
      dir_q <= dir_d;
      dw_q  <= dw_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      step_q  <= '0;
      dwell_q <= '0;
      steps_q <= '0;
    end else if (snap) begin
      base_q  <= cfg_base;
      step_q  <= cfg_step;
      dwell_q <= cfg_dwell;
      steps_q <= cfg_steps;
    end
  end

  assign lvl_next   = lvl_d;
  assign lvl        = lvl_q;
  assign base_snap  = base_q;
  assign step_snap  = step_q;
  assign steps_snap = steps_q;
endmodule

// File: rtl/pwm_len_calc.sv
module pwm_len_calc #(
  parameter int PER_W   = 16,
  parameter int STEP_W  = 8,
  parameter int NSTEP_W = 4
) (
  input  logic [NSTEP_W-1:0] lvl,
  input  logic [PER_W-1:0]   base_snap,
  input  logic [STEP_W-1:0]  step_snap,
  input  logic [PER_W-1:0]   cfg_base,
  output logic [PER_W-1:0]   len_next
);
  localparam int SUM_W = PER_W + STEP_W + NSTEP_W + 1;
  localparam logic [SUM_W-1:0] LEN_MAX = SUM_W'({PER_W{1'b1}});

  logic [SUM_W-1:0] sum;

  assign sum = SUM_W'(base_snap) + SUM_W'(lvl) * SUM_W'(step_snap);

  always_comb begin
    if (lvl == '0)          len_next = cfg_base;
    else if (sum > LEN_MAX) len_next = {PER_W{1'b1}};
    else                    len_next = sum[PER_W-1:0];
  end
endmodule

// File: rtl/pwm_dither_gen.sv
module pwm_dither_gen #(
  parameter int PER_W   = 16,
  parameter int STEP_W  = 8,
  parameter int DWELL_W = 4,
  parameter int NSTEP_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dith_en,
  input  logic [PER_W-1:0]   base_period,
  input  logic [STEP_W-1:0]  step_size,
  input  logic [DWELL_W-1:0] dwell_periods,
  input  logic [NSTEP_W-1:0] step_count,
  output logic [PER_W-1:0]   period_len,
  output logic [PER_W-1:0]   period_cnt,
  output logic               period_start
);
  logic               wrap, first;
  logic [PER_W-1:0]   len_next, base_q;
  logic [STEP_W-1:0]  step_q;
  logic [NSTEP_W-1:0] lvl_next, lvl_q, steps_q;

  pwm_period_counter #(.PER_W(PER_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .len_next(len_next),
    .cnt(period_cnt), .len(period_len), .start(period_start),
    .wrap(wrap), .first(first)
  );

  pwm_dither_stepper #(
    .PER_W(PER_W), .STEP_W(STEP_W), .DWELL_W(DWELL_W), .NSTEP_W(NSTEP_W)
  ) u_step (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .first(first), .en(dith_en),
    .cfg_base(base_period), .cfg_step(step_size),
    .cfg_dwell(dwell_periods), .cfg_steps(step_count),
    .lvl_next(lvl_next), .lvl(lvl_q), .base_snap(base_q),
    .step_snap(step_q), .steps_snap(steps_q)
  );

  pwm_len_calc #(.PER_W(PER_W), .STEP_W(STEP_W), .NSTEP_W(NSTEP_W)) u_calc (
    .lvl(lvl_next), .base_snap(base_q), .step_snap(step_q),
    .cfg_base(base_period), .len_next(len_next)
  );
endmodule

// File: rtl/pwm_dither_gen_chk.sv
module pwm_dither_gen_chk #(
  parameter int PER_W   = 16,
  parameter int NSTEP_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [PER_W-1:0]   period_len,
  input logic [PER_W-1:0]   period_cnt,
  input logic               period_start,
  input logic [NSTEP_W-1:0] lvl,
  input logic [NSTEP_W-1:0] steps_snap
);
  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (period_cnt == '0) || (period_cnt < period_len));

  assert_cnt_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (period_cnt != '0) |=> (period_cnt == '0) ||
                           (period_cnt == $past(period_cnt) + PER_W'(1)));

  assert_start_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |-> (period_cnt == '0));

  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start && (period_len > PER_W'(1))) |=> !period_start);

  assert_len_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start |-> $stable(period_len));

  assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= steps_snap);
endmodule

bind pwm_dither_gen pwm_dither_gen_chk #(.PER_W(PER_W), .NSTEP_W(NSTEP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .period_len(period_len), .period_cnt(period_cnt),
  .period_start(period_start), .lvl(lvl_q), .steps_snap(steps_q)
);

// File: tb/tb_pwm_dither_gen.sv
module tb_pwm_dither_gen;
  localparam int PW = 8, SW = 8, DW = 4, NW = 4;
  localparam int LMAX = (1 << PW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [PW-1:0] base = 8'd10;
  logic [SW-1:0] step = '0;
  logic [DW-1:0] dwell = '0;
  logic [NW-1:0] steps = '0;
  logic [PW-1:0] period_len, period_cnt;
  logic          period_start;

  pwm_dither_gen #(.PER_W(PW), .STEP_W(SW), .DWELL_W(DW), .NSTEP_W(NW)) dut (
    .clk(clk), .rst_n(rst_n), .dith_en(en), .base_period(base),
    .step_size(step), .dwell_periods(dwell), .step_count(steps),
    .period_len(period_len), .period_cnt(period_cnt), .period_start(period_start)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0, nrec = 0;
  int rec[0:63];
  bit done = 1'b0;

  // reference state derived from the requirements
  int m_cnt, m_len, m_lvl, m_dw, m_base, m_step, m_dwell, m_steps;
  bit m_up, m_start, m_first;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_edge();
    int nl, s;
    if (!rst_n) begin
      m_cnt = 0; m_len = 0; m_start = 0; m_first = 1;
      m_lvl = 0; m_up = 1; m_dw = 0;
      m_base = 0; m_step = 0; m_dwell = 0; m_steps = 0;
    end else if (m_first || (m_cnt + 1 >= m_len)) begin
      nl = m_lvl;
      if (m_first || !en) begin nl = 0; m_up = 1; m_dw = 0; end
      else if (m_dw < m_dwell) m_dw++;
      else begin
        m_dw = 0;
        if (m_steps == 0) begin nl = 0; m_up = 1; end
        else if (m_up) begin nl = m_lvl + 1; if (nl >= m_steps) m_up = 0; end
        else begin nl = m_lvl - 1; if (nl == 0) m_up = 1; end
      end
      m_lvl = nl;
      if (nl == 0) begin
        m_len = int'(base);
        m_base = int'(base); m_step = int'(step);
        m_dwell = int'(dwell); m_steps = int'(steps);
      end else begin
        s = m_base + nl * m_step;
        m_len = (s > LMAX) ? LMAX : s;
      end
      m_cnt = 0; m_start = 1; m_first = 0;
    end else begin
      m_cnt++; m_start = 0;
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    model_edge();
    chk(int'(period_cnt) == m_cnt, "R1 count", int'(period_cnt), m_cnt);
    chk(int'(period_start) == int'(m_start), "R2 strobe", int'(period_start), int'(m_start));
    chk(int'(period_len) == m_len, "R4 length", int'(period_len), m_len);
    if (period_start && nrec < 64) begin
      rec[nrec] = int'(period_len);
      nrec++;
    end
  endtask

  task automatic wait_rec(int n);
    for (int i = 0; i < 20000 && nrec < n; i++) cyc();
  endtask

  // reach a boundary with dithering off: level 0, direction up, dwell 0
  task automatic quiesce();
    en = 1'b0; nrec = 0; wait_rec(1); nrec = 0;
  endtask

  initial begin
    int e_sweep[10] = '{10, 12, 12, 14, 14, 12, 12, 10, 10, 12};
    int e_late[8]   = '{12, 16, 12, 8, 14, 20, 7, 13};
    int e_sat[4]    = '{255, 255, 255, 240};
    void'($urandom(32'd4711));

    // R11 reset state and first period
    cyc(); cyc();
    chk(period_cnt == '0 && period_len == '0, "R11 reset len", int'(period_len), 0);
    chk(period_start == 1'b0, "R11 reset strobe", int'(period_start), 0);
    rst_n = 1'b1;
    cyc();
    chk(period_start == 1'b1 && period_len == 8'd10, "R11 first period", int'(period_len), 10);

    // R3 / R7 fixed mode, base changed mid-period
    base = 8'd6; quiesce();
    cyc(); base = 8'd9;
    for (int i = 0; i < 3; i++) begin
      cyc();
      chk(period_len == 8'd6, "R7 held mid-period", int'(period_len), 6);
    end
    wait_rec(1);
    chk(rec[0] == 9, "R3 fixed base loaded", rec[0], 9);

    // R4 / R5 sweep with dwell 1, two levels
    base = 8'd10; step = 8'd2; steps = 4'd2; dwell = 4'd1; quiesce();
    en = 1'b1; wait_rec(10);
    for (int i = 0; i < 10; i++)
      chk(rec[i] == e_sweep[i], "R4 R5 sweep sequence", rec[i], e_sweep[i]);

    // R8 step change ignored mid-sweep, R9 disable and re-enable
    base = 8'd8; step = 8'd4; steps = 4'd2; dwell = 4'd0; quiesce();
    en = 1'b1; wait_rec(1);
    step = 8'd6; wait_rec(6);
    base = 8'd7; en = 1'b0; wait_rec(7);
    en = 1'b1; wait_rec(8);
    for (int i = 0; i < 6; i++)
      chk(rec[i] == e_late[i], "R8 capture at base only", rec[i], e_late[i]);
    for (int i = 6; i < 8; i++)
      chk(rec[i] == e_late[i], "R9 disable restarts sweep", rec[i], e_late[i]);

    // R6 zero level count
    base = 8'd5; step = 8'd5; steps = 4'd0; quiesce();
    en = 1'b1; wait_rec(4);
    for (int i = 0; i < 4; i++)
      chk(rec[i] == 5, "R6 no sweep with zero levels", rec[i], 5);

    // R10 saturation near full scale
    base = 8'd240; step = 8'd16; steps = 4'd2; quiesce();
    en = 1'b1; wait_rec(4);
    for (int i = 0; i < 4; i++)
      chk(rec[i] == e_sat[i], "R10 saturation", rec[i], e_sat[i]);

    // R1 one-cycle periods for lengths 1 and 0
    base = 8'd1; quiesce();
    for (int i = 0; i < 3; i++) begin
      cyc();
      chk(period_start == 1'b1, "R1 length 1 strobe", int'(period_start), 1);
    end
    base = 8'd0; cyc();
    for (int i = 0; i < 3; i++) begin
      cyc();
      chk(period_start == 1'b1 && period_cnt == '0, "R1 length 0 strobe", int'(period_start), 1);
    end

    // random configuration and enable changes against the model
    base = 8'd12; quiesce();
    for (int i = 0; i < 40000; i++) begin
      cyc();
      if ($urandom_range(0, 59) == 0) begin
        base  = PW'($urandom_range(0, 30));
        step  = SW'($urandom_range(0, 6));
        dwell = DW'($urandom_range(0, 3));
        steps = NW'($urandom_range(0, 5));
      end
      if ($urandom_range(0, 299) == 0) en = ~en;
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1900000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule